// File: doc/BRIEF.md
# Capture/Compare Counter Array

One 16-bit time base advances on every clock where the count enable is high, and a fixed number of capture/compare channels (three by default) watch it. Each channel has a mode byte, a 16-bit value and an input and output pin. The mode byte puts the channel into one of six functions: edge capture, timer match, toggle on match, square-wave frequency output, 8-bit PWM or 16-bit PWM. The time base wraps from 0xFFFF to 0x0000 and raises an overflow flag when it does. Each channel raises its own flag on its events. Software clears any flag by writing 0 to its bit.

Software reaches the block through a byte-wide register port. Writes take effect at the clock edge where the write strobe is sampled. Reads are combinational from the current address. A read of the counter low byte also freezes the current high byte into a shadow register. A later high-byte read returns that shadow, so the two bytes always belong to one count value.

Each channel's function is a state held in its mode byte. The states are CAPTURE (code 0), SWTIMER (1), HSOUT (2), FREQ (3), PWM8 (4) and PWM16 (5). Codes 6 and 7 select the inactive state RSV. The only transition between states is a write to the channel's mode register, which can move it from any state to any other in one clock. Every mode write also clears the channel's toggle flop.

Top module: `ccp_array`

## Requirements
- R1: The counter adds one on every clock with `cnt_en` high and holds otherwise. A write to address 0 loads the low byte and a write to address 1 loads the high byte, and a write has priority over counting.
- R2: When the counter wraps from 0xFFFF to 0x0000, flag bit 0 (overflow) is set.
- R3: Reading address 0 returns the low byte and latches the high byte. Reading address 1 returns that latched byte, even if the counter has moved since.
- R4: The flag register at address 2 has bit 0 for overflow and bit m+1 for channel m. Writing 0 to a bit clears it and writing 1 leaves it unchanged. A new event in the same cycle wins over the clear.
- R5: The channel m registers are mode at 4+4m, value low at 5+4m and value high at 6+4m. In the mode byte, bit 0 arms rising edges, bit 1 arms falling edges, bit 2 is the compare/PWM enable and bits 6:4 select the function. In CAPTURE, an armed edge on `cap_pin[m]` copies the counter into the value register and sets the channel flag. An edge that is not armed changes nothing.
- R6: In SWTIMER, the channel flag is set when the counter equals the value on a counting clock, and the output pin stays low.
- R7: In HSOUT, the output pin toggles and the flag is set on each counting clock where the counter equals the value.
- R8: In FREQ, the output toggles whenever the counter low byte equals value low. Value low then advances by value high, so the pin holds each level for value-high counts.
- R9: In PWM8 with the enable set, the output is high while the counter low byte is at least the 8-bit compare level. Level 0x00 gives 256/256 duty and level 0xFF gives 1/256. With the enable clear the output is low.
- R10: The PWM8 compare level is loaded from value high only on a counting clock where the counter low byte is 0xFF. A change to value high in mid-period does not alter the current period.
- R11: In PWM16 with the enable set, the output is high while the counter is at least the 16-bit value, so the value sets the number of low counts. With the enable clear the output is low.
- R12: Function codes 6 and 7 drive the output low and never set the channel flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count enable for the time base |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (latches high byte at address 0) |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | BYTE_W | Write data |
| bus_rdata | output | BYTE_W | Read data, combinational from address |
| cap_pin | input | NUM_MOD | Capture inputs, one per channel |
| out_pin | output | NUM_MOD | Channel outputs |
| mod_flag | output | NUM_MOD | Channel flags |
| ovf_flag | output | 1 | Counter overflow flag |

## Verification
A register write, an armed capture edge, a match or a low-byte wrap is seen one clock after the edge that samples it. The value, flag or toggle output then changes at that edge. The PWM outputs are combinational from the counter and the compare level, so they move in the same clock as the counter. The bench drives every stimulus just after a falling edge and samples just after the next falling edge, which lets exactly one rising edge intervene. Its per-cycle models of FREQ, PWM8 and PWM16 step once per intervening edge, and they reload the PWM8 level on the same clock as the hardware.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

    typedef enum logic [2:0] {
        K_CAPTURE = 3'd0,
        K_SWTIMER = 3'd1,
        K_HSOUT   = 3'd2,
        K_FREQ    = 3'd3,
        K_PWM8    = 3'd4,
        K_PWM16   = 3'd5,
        K_RSV6    = 3'd6,
        K_RSV7    = 3'd7
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  cmp_en;
        logic  fall_en;
        logic  rise_en;
    } mode_cfg_t;

    localparam int unsigned A_CNT_LO   = 0;
    localparam int unsigned A_CNT_HI   = 1;
    localparam int unsigned A_FLAGS    = 2;
    localparam int unsigned MOD_BASE   = 4;
    localparam int unsigned MOD_STRIDE = 4;
    localparam int unsigned OFS_MODE   = 0;
    localparam int unsigned OFS_VLO    = 1;
    localparam int unsigned OFS_VHI    = 2;

endpackage

// File: rtl/ccp_timebase.sv
module ccp_timebase #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cnt_en,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic                  rd_lo,
    input  logic [BYTE_W-1:0]     wdata,
    output logic [2*BYTE_W-1:0]   cnt,
    output logic [BYTE_W-1:0]     hi_shadow,
    output logic                  ovf_evt
);
    localparam int CW = 2 * BYTE_W;

    logic wr_any;

    always_comb begin
        wr_any  = wr_lo || wr_hi;
        ovf_evt = cnt_en && !wr_any && (cnt == {CW{1'b1}});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wr_any) begin
            if (wr_lo) cnt[BYTE_W-1:0]  <= wdata;
            if (wr_hi) cnt[CW-1:BYTE_W] <= wdata;
        end else if (cnt_en) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     hi_shadow <= '0;
        else if (rd_lo) hi_shadow <= cnt[CW-1:BYTE_W];
    end

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !wr_lo && !wr_hi) |=> (cnt == $past(cnt) + 1'b1));

    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !wr_lo && !wr_hi) |=> $stable(cnt));

    // R2
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> (cnt == '0));

endmodule

// File: rtl/ccp_module.sv
module ccp_module
    import ccp_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cnt_en,
    input  logic [2*BYTE_W-1:0]   cnt,
    input  logic                  pin_in,
    input  logic                  wr_mode,
    input  logic                  wr_vlo,
    input  logic                  wr_vhi,
    input  logic [BYTE_W-1:0]     wdata,
    output mode_cfg_t             cfg_o,
    output logic [2*BYTE_W-1:0]   val_o,
    output logic                  pin_out,
    output logic                  evt
);
    localparam int CW = 2 * BYTE_W;

    mode_cfg_t         cfg_q;
    logic [CW-1:0]     val_q;
    logic [BYTE_W-1:0] cmp8_q;
    logic              in_q;
    logic              tog_q;

    logic rise, fall, full_match, lo_match, lo_wrap;
    logic capt_hit, do_tog, freq_adv, out_c;

    // Output process: decodes the current function state.
    always_comb begin
        rise       = pin_in && !in_q;
        fall       = !pin_in && in_q;
        full_match = cnt_en && (cnt == val_q);
        lo_match   = cnt_en && (cnt[BYTE_W-1:0] == val_q[BYTE_W-1:0]);
        lo_wrap    = cnt_en && (cnt[BYTE_W-1:0] == {BYTE_W{1'b1}});
        capt_hit   = 1'b0;
        evt        = 1'b0;
        do_tog     = 1'b0;
        freq_adv   = 1'b0;
        out_c      = 1'b0;
        unique case (cfg_q.kind)
            K_CAPTURE: begin
                capt_hit = (rise && cfg_q.rise_en) || (fall && cfg_q.fall_en);
                evt      = capt_hit;
            end
            K_SWTIMER: begin
                evt = full_match;
            end
            K_HSOUT: begin
                evt    = full_match;
                do_tog = full_match;
                out_c  = tog_q;
            end
            K_FREQ: begin
                evt      = lo_match;
                do_tog   = lo_match;
                freq_adv = lo_match;
                out_c    = tog_q;
            end
            K_PWM8: begin
                out_c = cfg_q.cmp_en && (cnt[BYTE_W-1:0] >= cmp8_q);
            end
            K_PWM16: begin
                out_c = cfg_q.cmp_en && (cnt >= val_q);
            end
            default: begin
                out_c = 1'b0;
            end
        endcase
        pin_out = out_c;
        cfg_o   = cfg_q;
        val_o   = val_q;
    end

    // State register: function state changes only on a mode write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{kind: K_CAPTURE, cmp_en: 1'b0, fall_en: 1'b0, rise_en: 1'b0};
        end else if (wr_mode) begin
            cfg_q <= '{kind:    kind_e'(wdata[6:4]),
                       cmp_en:  wdata[2],
                       fall_en: wdata[1],
                       rise_en: wdata[0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (wr_vlo || wr_vhi) begin
            if (wr_vlo) val_q[BYTE_W-1:0]  <= wdata;
            if (wr_vhi) val_q[CW-1:BYTE_W] <= wdata;
        end else if (capt_hit) begin
            val_q <= cnt;
        end else if (freq_adv) begin
            val_q[BYTE_W-1:0] <= val_q[BYTE_W-1:0] + val_q[CW-1:BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q   <= 1'b0;
            tog_q  <= 1'b0;
            cmp8_q <= '0;
        end else begin
            in_q <= pin_in;
            if (wr_mode)     tog_q <= 1'b0;
            else if (do_tog) tog_q <= !tog_q;
            if (lo_wrap)     cmp8_q <= val_q[CW-1:BYTE_W];
        end
    end

    // R5
    capt_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.kind == K_CAPTURE && cfg_q.rise_en && pin_in && !in_q && !wr_vlo && !wr_vhi)
        |=> (val_q == $past(cnt)));

    // R7
    hs_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.kind == K_HSOUT && full_match && !wr_mode) |=> (pin_out != $past(pin_out)));

    // R10
    pwm8_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cnt_en && cnt[BYTE_W-1:0] == {BYTE_W{1'b1}})) |=> $stable(cmp8_q));

endmodule

// File: rtl/ccp_array.sv
module ccp_array
    import ccp_pkg::*;
#(
    parameter int NUM_MOD = 3,
    parameter int BYTE_W  = 8,
    parameter int ADDR_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cnt_en,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    input  logic [NUM_MOD-1:0]  cap_pin,
    output logic [NUM_MOD-1:0]  out_pin,
    output logic [NUM_MOD-1:0]  mod_flag,
    output logic                ovf_flag
);
    localparam int CW = 2 * BYTE_W;
    localparam int NF = NUM_MOD + 1;

    logic [CW-1:0]     cnt;
    logic [BYTE_W-1:0] hi_shadow;
    logic              ovf_evt;
    logic              wr_lo, wr_hi, rd_lo, flags_wr;
    logic [NUM_MOD-1:0] mod_evt;
    logic [NF-1:0]     evt_vec;
    logic [NF-1:0]     flag_q;
    mode_cfg_t         mode_arr [NUM_MOD];
    logic [CW-1:0]     val_arr  [NUM_MOD];

    always_comb begin
        wr_lo    = bus_wr && (bus_addr == ADDR_W'(A_CNT_LO));
        wr_hi    = bus_wr && (bus_addr == ADDR_W'(A_CNT_HI));
        flags_wr = bus_wr && (bus_addr == ADDR_W'(A_FLAGS));
        rd_lo    = bus_rd && (bus_addr == ADDR_W'(A_CNT_LO));
        evt_vec  = {mod_evt, ovf_evt};
    end

    ccp_timebase #(.BYTE_W(BYTE_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .rd_lo     (rd_lo),
        .wdata     (bus_wdata),
        .cnt       (cnt),
        .hi_shadow (hi_shadow),
        .ovf_evt   (ovf_evt)
    );

    for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
        localparam int unsigned BASE = MOD_BASE + MOD_STRIDE * m;
        logic wr_mode, wr_vlo, wr_vhi;
        always_comb begin
            wr_mode = bus_wr && (bus_addr == ADDR_W'(BASE + OFS_MODE));
            wr_vlo  = bus_wr && (bus_addr == ADDR_W'(BASE + OFS_VLO));
            wr_vhi  = bus_wr && (bus_addr == ADDR_W'(BASE + OFS_VHI));
        end
        ccp_module #(.BYTE_W(BYTE_W)) u_mod (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt_en  (cnt_en),
            .cnt     (cnt),
            .pin_in  (cap_pin[m]),
            .wr_mode (wr_mode),
            .wr_vlo  (wr_vlo),
            .wr_vhi  (wr_vhi),
            .wdata   (bus_wdata),
            .cfg_o   (mode_arr[m]),
            .val_o   (val_arr[m]),
            .pin_out (out_pin[m]),
            .evt     (mod_evt[m])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            for (int i = 0; i < NF; i++) begin
                if (evt_vec[i])                        flag_q[i] <= 1'b1;
                else if (flags_wr && !bus_wdata[i])    flag_q[i] <= 1'b0;
            end
        end
    end

    always_comb begin
        ovf_flag  = flag_q[0];
        mod_flag  = flag_q[NF-1:1];
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_CNT_LO))      bus_rdata = cnt[BYTE_W-1:0];
        else if (bus_addr == ADDR_W'(A_CNT_HI)) bus_rdata = hi_shadow;
        else if (bus_addr == ADDR_W'(A_FLAGS))  bus_rdata[NF-1:0] = flag_q;
        for (int m = 0; m < NUM_MOD; m++) begin
            if (bus_addr == ADDR_W'(MOD_BASE + MOD_STRIDE * m + OFS_MODE))
                bus_rdata = BYTE_W'({1'b0, mode_arr[m].kind, 1'b0, mode_arr[m].cmp_en,
                                     mode_arr[m].fall_en, mode_arr[m].rise_en});
            else if (bus_addr == ADDR_W'(MOD_BASE + MOD_STRIDE * m + OFS_VLO))
                bus_rdata = val_arr[m][BYTE_W-1:0];
            else if (bus_addr == ADDR_W'(MOD_BASE + MOD_STRIDE * m + OFS_VHI))
                bus_rdata = val_arr[m][CW-1:BYTE_W];
        end
    end

    // R4
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_wr && !bus_wdata[0] && !ovf_evt) |=> !ovf_flag);

    // R2
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_flag);

endmodule

// File: tb/tb_ccp_array.sv
module tb_ccp_array;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2:0] cap_pin = '0;
    logic [2:0] out_pin;
    logic [2:0] mod_flag;
    logic       ovf_flag;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    ccp_array dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_pin(cap_pin), .out_pin(out_pin), .mod_flag(mod_flag), .ovf_flag(ovf_flag)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=%0d exp=<100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 8'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 4'(a);
        #1 d = int'(bus_rdata);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_cnt(input int v);
        wr(0, v & 8'hFF);
        wr(1, (v >> 8) & 8'hFF);
    endtask

    task automatic rd_cnt(output int v);
        int lo, hi;
        rd(0, lo);
        rd(1, hi);
        v = (hi << 8) | lo;
    endtask

    task automatic rd_val(input int m, output int v);
        int lo, hi;
        rd(5 + 4 * m, lo);
        rd(6 + 4 * m, hi);
        v = (hi << 8) | lo;
    endtask

    task automatic run(input int n);
        @(negedge clk);
        cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic pwm8_duty(input int hv, input bit en, input string tag);
        int hi_cnt, exp_hi;
        wr(6 + 4 * 1, hv);
        wr(4 + 4 * 1, en ? 8'h44 : 8'h40);
        set_cnt(16'h00FF);
        run(1);
        hi_cnt = 0;
        @(negedge clk);
        cnt_en = 1'b1;
        for (int i = 0; i < 256; i++) begin
            hi_cnt += int'(out_pin[1]);
            @(negedge clk);
        end
        cnt_en = 1'b0;
        exp_hi = en ? (256 - hv) : 0;
        chk(tag, hi_cnt, exp_hi);
    endtask

    initial begin
        int v;
        int cnt_m, nm, step;
        bit tog_m;
        int cmp_m, hv_m, p16;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        rd_cnt(v);            chk("R1 reset count", v, 0);
        rd(2, v);             chk("R4 reset flags", v, 0);
        chk("R9 reset outputs", int'(out_pin), 0);

        // R1: load, count, hold
        set_cnt(16'h1234);
        rd_cnt(v);            chk("R1 load", v, 16'h1234);
        run(10);
        rd_cnt(v);            chk("R1 count 10", v, 16'h123E);
        repeat (5) @(negedge clk);
        rd_cnt(v);            chk("R1 hold", v, 16'h123E);

        // R3: coherent high byte
        set_cnt(16'h12F0);
        rd(0, v);             chk("R3 low byte", v, 8'hF0);
        run(300);
        rd(1, v);             chk("R3 latched high", v, 8'h12);
        rd_cnt(v);            chk("R3 fresh pair", v, 16'h141C);

        // R2 / R4: wrap and flag clearing
        set_cnt(16'hFFFE);
        wr(2, 0);
        run(1);
        rd(2, v);             chk("R2 no flag before wrap", v & 1, 0);
        run(1);
        rd_cnt(v);            chk("R2 wrapped count", v, 0);
        rd(2, v);             chk("R2 overflow flag", v & 1, 1);
        wr(2, 8'hFF);
        rd(2, v);             chk("R4 write one keeps", v & 1, 1);
        wr(2, 8'hFE);
        rd(2, v);             chk("R4 write zero clears", v & 1, 0);

        // R5: capture on channel 0
        wr(4, 8'h01);
        set_cnt(16'h0ABC);
        wr(2, 0);
        @(negedge clk); cap_pin[0] = 1'b1;
        repeat (2) @(negedge clk);
        rd_val(0, v);         chk("R5 rise capture", v, 16'h0ABC);
        rd(2, v);             chk("R5 rise flag", (v >> 1) & 1, 1);
        wr(2, 0);
        set_cnt(16'h0DEF);
        @(negedge clk); cap_pin[0] = 1'b0;
        repeat (2) @(negedge clk);
        rd_val(0, v);         chk("R5 fall ignored value", v, 16'h0ABC);
        rd(2, v);             chk("R5 fall ignored flag", (v >> 1) & 1, 0);
        wr(4, 8'h02);
        set_cnt(16'h1111);
        @(negedge clk); cap_pin[0] = 1'b1;
        repeat (2) @(negedge clk);
        rd(2, v);             chk("R5 rise ignored flag", (v >> 1) & 1, 0);
        rd_val(0, v);         chk("R5 rise ignored value", v, 16'h0ABC);
        @(negedge clk); cap_pin[0] = 1'b0;
        repeat (2) @(negedge clk);
        rd_val(0, v);         chk("R5 fall capture", v, 16'h1111);
        rd(2, v);             chk("R5 fall flag", (v >> 1) & 1, 1);
        wr(4, 8'h03);
        set_cnt(16'h2222);
        wr(2, 0);
        @(negedge clk); cap_pin[0] = 1'b1;
        repeat (2) @(negedge clk);
        rd_val(0, v);         chk("R5 both rise", v, 16'h2222);
        set_cnt(16'h3333);
        @(negedge clk); cap_pin[0] = 1'b0;
        repeat (2) @(negedge clk);
        rd_val(0, v);         chk("R5 both fall", v, 16'h3333);
        rd(4, v);             chk("R5 mode readback", v, 8'h03);

        // R6: timer match on channel 1
        wr(5 + 4, 8'h05); wr(6 + 4, 8'h00);
        wr(4 + 4, 8'h10);
        set_cnt(0);
        wr(2, 0);
        run(5);
        rd(2, v);             chk("R6 before match", (v >> 2) & 1, 0);
        run(1);
        rd(2, v);             chk("R6 match flag", (v >> 2) & 1, 1);
        chk("R6 output low", int'(out_pin[1]), 0);

        // R7: toggle on match on channel 2
        wr(5 + 8, 8'h03); wr(6 + 8, 8'h00);
        wr(4 + 8, 8'h20);
        set_cnt(0);
        wr(2, 0);
        chk("R7 initial low", int'(out_pin[2]), 0);
        run(4);
        chk("R7 first toggle", int'(out_pin[2]), 1);
        rd(2, v);             chk("R7 flag", (v >> 3) & 1, 1);
        run(2);
        chk("R7 no extra toggle", int'(out_pin[2]), 1);
        set_cnt(0);
        run(4);
        chk("R7 second toggle", int'(out_pin[2]), 0);

        // R8: frequency output on channel 0, half period 4 then 7
        for (int s = 0; s < 2; s++) begin
            step = (s == 0) ? 4 : 7;
            wr(5, 8'h00); wr(6, step);
            wr(4, 8'h30);
            set_cnt(0);
            cnt_m = 0; nm = 0; tog_m = 1'b0;
            @(negedge clk);
            cnt_en = 1'b1;
            for (int i = 0; i < 40; i++) begin
                chk("R8 freq output", int'(out_pin[0]), int'(tog_m));
                @(negedge clk);
                if ((cnt_m & 8'hFF) == nm) begin
                    tog_m = !tog_m;
                    nm = (nm + step) & 8'hFF;
                end
                cnt_m = (cnt_m + 1) & 16'hFFFF;
            end
            cnt_en = 1'b0;
        end

        // R9: PWM8 duty over one low-byte period
        pwm8_duty(8'h00, 1'b1, "R9 duty 0x00");
        pwm8_duty(8'h01, 1'b1, "R9 duty 0x01");
        pwm8_duty(8'h40, 1'b1, "R9 duty 0x40");
        pwm8_duty(8'hFF, 1'b1, "R9 duty 0xFF");
        pwm8_duty(8'h80, 1'b0, "R9 disabled");

        // R10: mid-period change waits for wrap
        wr(6 + 4, 8'h80);
        wr(4 + 4, 8'h44);
        set_cnt(16'h00FF);
        run(1);
        wr(6 + 4, 8'h20);
        cnt_m = 16'h0100; cmp_m = 8'h80; hv_m = 8'h20;
        @(negedge clk);
        cnt_en = 1'b1;
        for (int i = 0; i < 300; i++) begin
            chk("R10 reload timing", int'(out_pin[1]), int'((cnt_m & 8'hFF) >= cmp_m));
            @(negedge clk);
            if ((cnt_m & 8'hFF) == 8'hFF) cmp_m = hv_m;
            cnt_m = (cnt_m + 1) & 16'hFFFF;
        end
        cnt_en = 1'b0;

        // R11: PWM16 across the wrap, and edge cases
        wr(5 + 8, 8'h03); wr(6 + 8, 8'h00);
        wr(4 + 8, 8'h54);
        set_cnt(16'hFFFC);
        cnt_m = 16'hFFFC; p16 = 3;
        @(negedge clk);
        cnt_en = 1'b1;
        for (int i = 0; i < 10; i++) begin
            chk("R11 pwm16", int'(out_pin[2]), int'(cnt_m >= p16));
            @(negedge clk);
            cnt_m = (cnt_m + 1) & 16'hFFFF;
        end
        cnt_en = 1'b0;
        wr(5 + 8, 8'h00);
        chk("R11 value zero full high", int'(out_pin[2]), 1);
        wr(4 + 8, 8'h50);
        chk("R11 disabled low", int'(out_pin[2]), 0);

        // R12: reserved codes
        for (int k = 6; k < 8; k++) begin
            wr(4, (k << 4) | 8'h07);
            wr(5, 8'h10); wr(6, 8'h00);
            set_cnt(16'h000E);
            wr(2, 0);
            @(negedge clk); cap_pin[0] = 1'b1;
            run(6);
            cap_pin[0] = 1'b0;
            run(2);
            rd(2, v);         chk("R12 reserved flag", (v >> 1) & 1, 0);
            chk("R12 reserved output", int'(out_pin[0]), 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule